// File: doc/BRIEF.md
# Retrofit Interrupt Controller

This block gives interrupt capability to a 16-bit-instruction processor that has no interrupt support of its own. It sits in the instruction path between program memory and the processor. It watches every fetched word and its address, and on the way through it may swap that word for one it builds itself. The processor never knows that an interrupt took place: it only sees an ordinary jump.

An interrupt request may arrive at any time. It is first brought into the clock domain and then held as pending. At the first fetch where an interrupt is allowed, the fetched word is replaced by a jump to a fixed vector. At the same moment, the address of the displaced word is kept as the return address. The handler finishes with a jump to the all-ones target. While the handler runs, the block replaces that word with a jump back to the saved address, so the displaced instruction is fetched again.

The block also tracks the two I/O bank selections, left and right. It copies the bank address on each select strobe, but only while no handler is running. Software can therefore read back the selections that were in force at interrupt time and re-select them before it returns.

Top module: `irq_retrofit`

## Requirements
- R1: Outside the forced-vector and return cases, `cpu_instr` equals `mem_instr` in the same cycle.
- R2: The request goes through a two-stage synchronizer and a rise detector. A request that first goes high before clock edge k becomes pending at edge k+2. The earliest forced jump therefore appears in the fetch cycle that follows edge k+2.
- R3: The forced word is a jump: opcode bits [15:13] = 3'b111, and bits [12:0] = the vector parameter (default 1, giving 16'hE001). At the edge that ends that cycle, `ret_addr` takes the `pc_addr` of the displaced fetch.
- R4: `in_service` rises at the edge after a forced jump. While it is high, no further jump is forced (no nesting), and `ret_addr` holds its value.
- R5: While `in_service` is high, a fetched word of 16'hFFFF (jump opcode 3'b111 with all-ones target) is replaced by a jump to `ret_addr`. `in_service` clears at the following edge.
- R6: While `in_service` is low, a fetched 16'hFFFF passes through unchanged.
- R7: No jump is forced while the fetched word is an execute-indirect instruction (opcode 3'b110). No jump is forced in the fetch cycle directly after one either.
- R8: A pending request is kept while it is blocked, whether by the execute-indirect rule or by a running handler. It is serviced at the first allowed fetch, which may be the one directly after a return.
- R9: A high `left_sel_stb` or `right_sel_stb` copies `bank_addr` into `saved_left` or `saved_right` at the edge, but only while `in_service` is low. While `in_service` is high, strobes are ignored.
- R10: A synchronous active-high reset clears `in_service`, the pending request, `ret_addr`, `saved_left` and `saved_right`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one instruction cycle per period |
| rst | input | 1 | Synchronous reset, active high |
| irq_async | input | 1 | Interrupt request, asynchronous to clk |
| pc_addr | input | 13 | Address of the word being fetched |
| mem_instr | input | 16 | Word read from program memory |
| cpu_instr | output | 16 | Word delivered to the processor's instruction input |
| bank_addr | input | 8 | Bank address carried during a select strobe |
| left_sel_stb | input | 1 | Left bank select strobe |
| right_sel_stb | input | 1 | Right bank select strobe |
| saved_left | output | 8 | Last left bank address captured outside a handler |
| saved_right | output | 8 | Last right bank address captured outside a handler |
| ret_addr | output | 13 | Address to resume at after the handler |
| in_service | output | 1 | High from the forced jump until the return |

## Verification
Several rules are checked by assertions on every cycle. Each entry into service must follow a vector jump word on the bus. A return word inside a handler must end service. Service must never start from an execute-indirect fetch or from the fetch just after one. A handler must hold `ret_addr`, the pending request and both saved banks steady. A synchronized rise must always leave a request pending.

Other behaviour can only be shown by the bench's cycle-exact scenarios: the exact three-edge request latency, pass-through of the return word outside a handler, and a request that is blocked by execute-indirect and then serviced two fetches later. The same goes for a request that arrives during a handler and is serviced on the fetch right after the return, and the bank values that software will read back.

// File: rtl/irq_retrofit_pkg.sv
package irq_retrofit_pkg;

    localparam int OP_W    = 3;
    localparam int ADDR_W  = 13;
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int BANK_W  = 8;
    localparam int N_BANKS = 2;

    localparam logic [OP_W-1:0] OP_XEC = 3'b110;
    localparam logic [OP_W-1:0] OP_JMP = 3'b111;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] target;
    } instr_t;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_VEC,
        SRC_RET
    } bus_src_e;

    function automatic instr_t jmp_to(input logic [ADDR_W-1:0] a);
        instr_t w;
        w.op     = OP_JMP;
        w.target = a;
        return w;
    endfunction

    function automatic logic is_ret_word(input instr_t w);
        return (w.op == OP_JMP) && (&w.target);
    endfunction

    function automatic logic is_xec_word(input instr_t w);
        return w.op == OP_XEC;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/irq_decode.sv
module irq_decode
    import irq_retrofit_pkg::*;
(
    input  instr_t word,
    output logic   is_xec,
    output logic   is_ret
);
    always_comb begin
        is_xec = is_xec_word(word);
        is_ret = is_ret_word(word);
    end
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        stb,
    input  logic [W-1:0]        din,
    input  logic                block,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (stb[i] && !block)
                q[i] <= din;
        end
    end

    // R9: a running handler freezes every saved selection
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
        block |=> $stable(q));

endmodule

// File: rtl/irq_retrofit.sv
module irq_retrofit
    import irq_retrofit_pkg::*;
#(
    parameter logic [12:0] VEC_ADDR = 13'h0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_async,
    input  logic [12:0] pc_addr,
    input  logic [15:0] mem_instr,
    output logic [15:0] cpu_instr,
    input  logic [7:0]  bank_addr,
    input  logic        left_sel_stb,
    input  logic        right_sel_stb,
    output logic [7:0]  saved_left,
    output logic [7:0]  saved_right,
    output logic [12:0] ret_addr,
    output logic        in_service
);
    instr_t                         mem_w;
    logic                           cur_xec, cur_ret, req_rise;
    logic                           pending, prev_xec, svc;
    logic [ADDR_W-1:0]              ret_q;
    bus_src_e                       src;
    logic [N_BANKS-1:0][BANK_W-1:0] banks;

    assign mem_w = instr_t'(mem_instr);

    irq_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_in(irq_async), .rise(req_rise)
    );

    irq_decode u_dec (
        .word(mem_w), .is_xec(cur_xec), .is_ret(cur_ret)
    );

    always_comb begin
        src = SRC_MEM;
        if (svc && cur_ret)
            src = SRC_RET;
        else if (!svc && pending && !cur_xec && !prev_xec)
            src = SRC_VEC;
    end

    always_comb begin
        case (src)
            SRC_VEC: cpu_instr = jmp_to(VEC_ADDR);
            SRC_RET: cpu_instr = jmp_to(ret_q);
            default: cpu_instr = mem_instr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            prev_xec <= 1'b0;
            svc      <= 1'b0;
            ret_q    <= '0;
        end else begin
            prev_xec <= cur_xec;
            pending  <= (pending && src != SRC_VEC) || req_rise;
            if (src == SRC_VEC) begin
                svc   <= 1'b1;
                ret_q <= pc_addr;
            end else if (src == SRC_RET) begin
                svc   <= 1'b0;
            end
        end
    end

    bank_latch #(.W(BANK_W), .N(N_BANKS)) u_banks (
        .clk(clk), .rst(rst),
        .stb({right_sel_stb, left_sel_stb}),
        .din(bank_addr), .block(svc), .q(banks)
    );

    assign saved_left  = banks[0];
    assign saved_right = banks[1];
    assign ret_addr    = ret_q;
    assign in_service  = svc;

    // R2: a synchronized rise always leaves a request pending
    p_pend_set_r2: assert property (@(posedge clk) disable iff (rst)
        req_rise |=> pending);

    // R3: entry into service is preceded by the vector jump on the bus
    p_vec_word_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(svc) |-> $past(cpu_instr) == 16'(jmp_to(VEC_ADDR)));

    // R4: no nesting, return address steady inside a handler
    p_no_nest_r4: assert property (@(posedge clk) disable iff (rst)
        (svc && !cur_ret) |=> (svc && $stable(ret_q)));

    // R5: return word inside a handler ends service
    p_ret_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (svc && cur_ret) |=> !svc);

    // R7: execute-indirect fetch never starts service
    p_xec_now_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_xec && !svc) |=> !svc);

    // R7: nor does the fetch right after it
    p_xec_next_r7: assert property (@(posedge clk) disable iff (rst)
        (prev_xec && !svc) |=> !svc);

    // R8: a request waiting on a handler is kept
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pending && svc) |=> pending);

endmodule

// File: tb/sim_irq_retrofit.sv
module sim_irq_retrofit;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_async;
    logic [12:0] pc_addr;
    logic [15:0] mem_instr;
    logic [15:0] cpu_instr;
    logic [7:0]  bank_addr;
    logic        left_sel_stb, right_sel_stb;
    logic [7:0]  saved_left, saved_right;
    logic [12:0] ret_addr;
    logic        in_service;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    irq_retrofit u0 (
        .clk(clk), .rst(rst), .irq_async(irq_async),
        .pc_addr(pc_addr), .mem_instr(mem_instr), .cpu_instr(cpu_instr),
        .bank_addr(bank_addr), .left_sel_stb(left_sel_stb),
        .right_sel_stb(right_sel_stb), .saved_left(saved_left),
        .saved_right(saved_right), .ret_addr(ret_addr),
        .in_service(in_service)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: one fetch cycle, expected bus word pushed to the scoreboard
    task automatic cyc(input logic [12:0] pc, input logic [15:0] mem,
                       input logic [15:0] exp, input string tag,
                       input logic ls = 1'b0, input logic rs = 1'b0,
                       input logic [7:0] bk = 8'h00);
        @(negedge clk);
        pc_addr       = pc;
        mem_instr     = mem;
        left_sel_stb  = ls;
        right_sel_stb = rs;
        bank_addr     = bk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic after_edge;
        @(posedge clk);
        #1;
    endtask

    // monitor: compare the bus word away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(32'(cpu_instr), 32'(e), t);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_async = 1'b0; pc_addr = '0; mem_instr = '0;
        bank_addr = '0; left_sel_stb = 1'b0; right_sel_stb = 1'b0;
        repeat (2) after_edge;
        chk(32'(in_service), 0, "R10 in_service");
        chk(32'(saved_left), 0, "R10 saved_left");
        chk(32'(saved_right), 0, "R10 saved_right");
        chk(32'(ret_addr), 0, "R10 ret_addr");
        @(negedge clk);
        rst = 1'b0;

        // R1 pass-through, R6 return word outside a handler
        cyc(13'h010, 16'h1234, 16'h1234, "R1");
        cyc(13'h011, 16'hC0DE, 16'hC0DE, "R1 xec");
        cyc(13'h012, 16'hE005, 16'hE005, "R1 jmp");
        cyc(13'h013, 16'hFFFF, 16'hFFFF, "R6");

        // R9 bank capture outside a handler
        cyc(13'h014, 16'h0100, 16'h0100, "R1", 1'b1, 1'b0, 8'h5A);
        after_edge;
        chk(32'(saved_left), 32'h5A, "R9 left capture");
        cyc(13'h015, 16'h0200, 16'h0200, "R1", 1'b0, 1'b1, 8'hA5);
        after_edge;
        chk(32'(saved_right), 32'hA5, "R9 right capture");
        chk(32'(saved_left), 32'h5A, "R9 left kept");

        // R2/R3: request, forced jump on the fourth fetch
        cyc(13'h020, 16'h1111, 16'h1111, "R2 edge1");
        irq_async = 1'b1;
        cyc(13'h021, 16'h2222, 16'h2222, "R2 edge2");
        cyc(13'h022, 16'h3333, 16'h3333, "R2 edge3");
        cyc(13'h023, 16'h4444, 16'hE001, "R3 vector");
        after_edge;
        chk(32'(in_service), 1, "R4 in_service set");
        chk(32'(ret_addr), 32'h023, "R3 ret_addr");
        irq_async = 1'b0;

        // R9 ignored strobe inside the handler
        cyc(13'h001, 16'h0A0B, 16'h0A0B, "R4", 1'b1, 1'b0, 8'h77);
        after_edge;
        chk(32'(saved_left), 32'h5A, "R9 strobe ignored");

        // R4/R8: new request during the handler, no nesting
        cyc(13'h002, 16'h0C0D, 16'h0C0D, "R4");
        irq_async = 1'b1;
        cyc(13'h003, 16'h0E0F, 16'h0E0F, "R4");
        irq_async = 1'b0;
        for (int i = 0; i < 4; i++)
            cyc(13'h004 + 13'(i), 16'h0500 + 16'(i), 16'h0500 + 16'(i), "R4 no nest");
        chk(32'(ret_addr), 32'h023, "R4 ret_addr held");

        // R5 return, then R8 pending serviced at once
        cyc(13'h008, 16'hFFFF, 16'hE023, "R5 return");
        after_edge;
        chk(32'(in_service), 0, "R5 in_service clear");
        cyc(13'h023, 16'h4444, 16'hE001, "R8 serviced");
        after_edge;
        chk(32'(in_service), 1, "R8 in_service");
        chk(32'(ret_addr), 32'h023, "R8 ret_addr");
        cyc(13'h009, 16'hFFFF, 16'hE023, "R5 return 2");
        after_edge;
        chk(32'(in_service), 0, "R5 clear 2");

        cyc(13'h023, 16'hFFFF, 16'hFFFF, "R6 after return");
        cyc(13'h024, 16'h0300, 16'h0300, "R1", 1'b0, 1'b1, 8'h3C);
        after_edge;
        chk(32'(saved_right), 32'h3C, "R9 capture after return");

        // R7/R8: request blocked by execute-indirect and its target fetch
        cyc(13'h03A, 16'h2001, 16'h2001, "R2");
        irq_async = 1'b1;
        cyc(13'h03B, 16'h4002, 16'h4002, "R2");
        cyc(13'h03C, 16'h6003, 16'h6003, "R2");
        cyc(13'h03D, 16'hC0A5, 16'hC0A5, "R7 xec");
        cyc(13'h0A5, 16'h8004, 16'h8004, "R7 after xec");
        cyc(13'h040, 16'h0005, 16'hE001, "R8 after block");
        after_edge;
        irq_async = 1'b0;
        chk(32'(ret_addr), 32'h040, "R3 ret_addr xec");
        cyc(13'h002, 16'hFFFF, 16'hE040, "R5 return 3");
        after_edge;
        chk(32'(in_service), 0, "R5 clear 3");

        repeat (2) @(negedge clk);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule